// File: doc/BRIEF.md
# Transmit Flow-Control Credit Gate

This block sits on the transmit side of one virtual channel and decides, cycle by cycle, whether a candidate transaction packet may go out on the link. It keeps six credit pools: a header pool and a data pool for each of the posted, non-posted and completion categories. Each pool holds the limit advertised by the link partner, the running count of credits already spent, and a flag that marks the pool as unlimited.

A requester presents the packet category and its payload size in bytes. The gate prices the packet at one header credit plus one data credit per started 16-byte unit. It checks both pools of that category with wrap-around arithmetic and raises a single-cycle grant when both have room. On a grant the cost is added to the spent counters. When the gate refuses, nothing changes, so the requester can hold the packet and ask again.

Limits arrive as initialization and update events, which have already been decoded from link-layer packets. An initialization-done input locks the channel. Sending is possible only after the lock, initialization events count only before it, and update events count only after it.

Top module: `txfc_credit_gate`

## Requirements
- R1: After reset, and until `vc_init_done` has been seen high at a clock edge, `tx_grant` stays low for every request. Once set, the lock stays set until reset.
- R2: The data cost of a request is ceil(`req_bytes` / 16). A zero-byte request costs no data credit, and a 10-byte request costs one.
- R3: Every granted request costs exactly one header credit of its own category. The three categories draw on separate pools.
- R4: A pool with limit L and spent count C admits cost K when (L − (C + K)) mod 2^W ≤ 2^(W−1), where W is 8 for header pools and 12 for data pools. A grant requires both pools of the category to admit.
- R5: An initialization event whose header or data value is zero makes that pool unlimited, and that pool then always admits.
- R6: An update event aimed at an unlimited pool leaves it unchanged.
- R7: An initialization event loads its category's limits and clears their spent counts only while unlocked. An update event replaces finite limits only while locked. Events at any other time are ignored.
- R8: A refused request changes no counter, so an identical later request sees the same credit state.
- R9: Categories are encoded posted = 0, non-posted = 1, completion = 2. Code 3 is never granted.
- R10: Limits and spent counters wrap modulo 2^W, so gating stays correct after the counts pass their field range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_init | input | 1 | Initialization credit event strobe |
| fc_update | input | 1 | Update credit event strobe |
| fc_cat | input | 2 | Category addressed by the credit event |
| fc_hdr | input | 8 | Advertised header limit |
| fc_data | input | 12 | Advertised data limit |
| vc_init_done | input | 1 | Channel initialization complete; sets the lock |
| req_valid | input | 1 | Candidate packet present |
| req_cat | input | 2 | Candidate packet category |
| req_bytes | input | 13 | Candidate payload size in bytes |
| tx_grant | output | 1 | Packet accepted this cycle; credits are charged at the edge |

## Verification
A long mixed sweep runs all four category codes and payload sizes spread over 0 to 299 bytes, with top-up updates of varying size. This compares every grant with an arithmetic model, and it drives both header and data counters past their wrap points. Byte counts just below and just above 16-byte multiples against a tight data limit show whether the rounding is right. A refusal followed by a smaller request that fits shows that a refused request charged nothing. Events sent on the wrong side of the lock, and updates sent to pools that became unlimited through a zero initial value, separate an event that was properly ignored from one that changed a limit.

// File: rtl/txfc_pkg.sv
package txfc_pkg;

    localparam int NUM_CAT = 3;

    typedef enum logic [1:0] {
        CAT_POSTED    = 2'd0,
        CAT_NONPOSTED = 2'd1,
        CAT_COMPL     = 2'd2,
        CAT_RSVD      = 2'd3
    } tlp_cat_e;

    localparam int BYTES_PER_CREDIT_LG2 = 4;

endpackage

// File: rtl/txfc_cost.sv
module txfc_cost #(
    parameter int LEN_W  = 13,
    parameter int DATA_W = 12
) (
    input  logic [LEN_W-1:0]  bytes,
    output logic [DATA_W-1:0] cost
);
    import txfc_pkg::*;

    localparam int SUM_W = LEN_W + 1;
    localparam logic [SUM_W-1:0] ROUND_UP = SUM_W'((1 << BYTES_PER_CREDIT_LG2) - 1);

    logic [SUM_W-1:0] padded;

    always_comb begin
        padded = {1'b0, bytes} + ROUND_UP;
        cost   = DATA_W'(padded >> BYTES_PER_CREDIT_LG2);
    end

endmodule

// File: rtl/txfc_pool.sv
module txfc_pool #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_ld,
    input  logic         upd_ld,
    input  logic [W-1:0] adv,
    input  logic [W-1:0] cost,
    input  logic         consume,
    output logic         ok
);

    localparam logic [W:0] HALF = (W+1)'(1) << (W - 1);

    typedef struct packed {
        logic [W-1:0] limit;
        logic [W-1:0] used;
        logic         inf;
    } pool_t;

    pool_t        st_q, st_d;
    logic [W-1:0] headroom;

    always_comb begin
        st_d = st_q;
        if (init_ld) begin
            st_d.limit = adv;
            st_d.inf   = (adv == '0);
            st_d.used  = '0;
        end else begin
            if (upd_ld && !st_q.inf) begin
                st_d.limit = adv;
            end
            if (consume) begin
                st_d.used = st_q.used + cost;
            end
        end
        headroom = st_q.limit - st_q.used - cost;
        ok       = st_q.inf || ({1'b0, headroom} <= HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    used_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!consume && !init_ld) |=> $stable(st_q.used));

    // R6
    inf_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.inf && !init_ld) |=> $stable(st_q.limit));

    // R4
    consume_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> ok);

    // R10
    used_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !init_ld) |=> (st_q.used == W'($past(st_q.used) + $past(cost))));

endmodule

// File: rtl/txfc_credit_gate.sv
module txfc_credit_gate #(
    parameter int HDR_W  = 8,
    parameter int DATA_W = 12,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fc_init,
    input  logic              fc_update,
    input  logic [1:0]        fc_cat,
    input  logic [HDR_W-1:0]  fc_hdr,
    input  logic [DATA_W-1:0] fc_data,
    input  logic              vc_init_done,
    input  logic              req_valid,
    input  logic [1:0]        req_cat,
    input  logic [LEN_W-1:0]  req_bytes,
    output logic              tx_grant
);
    import txfc_pkg::*;

    localparam logic [HDR_W-1:0] HDR_COST = HDR_W'(1);

    typedef struct packed {
        logic ready;
    } ctl_t;

    ctl_t              ctl_q, ctl_d;
    logic [DATA_W-1:0] data_cost;
    logic [NUM_CAT-1:0] hdr_ok, data_ok, cat_hit;
    logic              cat_legal;
    logic              grant;

    txfc_cost #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_cost (
        .bytes (req_bytes),
        .cost  (data_cost)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (vc_init_done) begin
            ctl_d.ready = 1'b1;
        end
        cat_legal = (tlp_cat_e'(req_cat) != CAT_RSVD);
        grant     = 1'b0;
        for (int c = 0; c < NUM_CAT; c++) begin
            cat_hit[c] = (req_cat == 2'(c));
            if (cat_hit[c] && hdr_ok[c] && data_ok[c]) begin
                grant = 1'b1;
            end
        end
        grant    = grant && req_valid && ctl_q.ready && cat_legal;
        tx_grant = grant;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < NUM_CAT; g++) begin : g_cat
        logic ev_hit;
        logic init_ld;
        logic upd_ld;
        logic take;

        assign ev_hit  = (fc_cat == 2'(g));
        assign init_ld = fc_init && !ctl_q.ready && ev_hit;
        assign upd_ld  = fc_update && ctl_q.ready && ev_hit;
        assign take    = grant && cat_hit[g];

        txfc_pool #(.W(HDR_W)) u_hdr (
            .clk     (clk),
            .rst_n   (rst_n),
            .init_ld (init_ld),
            .upd_ld  (upd_ld),
            .adv     (fc_hdr),
            .cost    (HDR_COST),
            .consume (take),
            .ok      (hdr_ok[g])
        );

        txfc_pool #(.W(DATA_W)) u_data (
            .clk     (clk),
            .rst_n   (rst_n),
            .init_ld (init_ld),
            .upd_ld  (upd_ld),
            .adv     (fc_data),
            .cost    (data_cost),
            .consume (take),
            .ok      (data_ok[g])
        );
    end

    // R1
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.ready |=> ctl_q.ready);

    // R1
    prelock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.ready |-> !tx_grant);

    // R9
    rsvd_cat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> (req_cat != 2'd3));

    // R3
    one_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cat_hit));

endmodule

// File: tb/txfc_credit_gate_tb.sv
module txfc_credit_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fc_init = 1'b0, fc_update = 1'b0;
    logic [1:0]  fc_cat = 2'd0;
    logic [7:0]  fc_hdr = 8'd0;
    logic [11:0] fc_data = 12'd0;
    logic        vc_init_done = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cat = 2'd0;
    logic [12:0] req_bytes = 13'd0;
    logic        tx_grant;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int lim_h[3], con_h[3], lim_d[3], con_d[3];
    bit inf_h[3], inf_d[3];
    bit m_ready;

    always #2.5 clk = ~clk;

    txfc_credit_gate u_dut (
        .clk(clk), .rst_n(rst_n),
        .fc_init(fc_init), .fc_update(fc_update), .fc_cat(fc_cat),
        .fc_hdr(fc_hdr), .fc_data(fc_data), .vc_init_done(vc_init_done),
        .req_valid(req_valid), .req_cat(req_cat), .req_bytes(req_bytes),
        .tx_grant(tx_grant)
    );

    function automatic bit fits(int lim, int con, int cost, int w);
        int mask = (1 << w) - 1;
        int diff = (lim - con - cost) & mask;
        return diff <= (1 << (w - 1));
    endfunction

    task automatic model_clear();
        for (int c = 0; c < 3; c++) begin
            lim_h[c] = 0; con_h[c] = 0; lim_d[c] = 0; con_d[c] = 0;
            inf_h[c] = 0; inf_d[c] = 0;
        end
        m_ready = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: tx_grant=%0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fc_event(bit is_init, int cat, int h, int d);
        @(negedge clk);
        fc_init = is_init; fc_update = !is_init;
        fc_cat = 2'(cat); fc_hdr = 8'(h); fc_data = 12'(d);
        @(posedge clk);
        if (is_init && !m_ready) begin
            lim_h[cat] = h & 255; inf_h[cat] = ((h & 255) == 0); con_h[cat] = 0;
            lim_d[cat] = d & 4095; inf_d[cat] = ((d & 4095) == 0); con_d[cat] = 0;
        end else if (!is_init && m_ready) begin
            if (!inf_h[cat]) lim_h[cat] = h & 255;
            if (!inf_d[cat]) lim_d[cat] = d & 4095;
        end
        #1;
        fc_init = 1'b0; fc_update = 1'b0;
    endtask

    task automatic lock();
        @(negedge clk);
        vc_init_done = 1'b1;
        @(posedge clk);
        m_ready = 1;
        #1;
        vc_init_done = 1'b0;
    endtask

    task automatic try_send(string tag, int cat, int len);
        bit exp;
        int dcost = (len + 15) / 16;
        @(negedge clk);
        req_valid = 1'b1; req_cat = 2'(cat); req_bytes = 13'(len);
        #1;
        exp = 0;
        if (m_ready && cat < 3) begin
            exp = (inf_h[cat] || fits(lim_h[cat], con_h[cat], 1, 8)) &&
                  (inf_d[cat] || fits(lim_d[cat], con_d[cat], dcost, 12));
        end
        check(tag, tx_grant, exp);
        @(posedge clk);
        if (exp) begin
            con_h[cat] = (con_h[cat] + 1) & 255;
            con_d[cat] = (con_d[cat] + dcost) & 4095;
        end
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // Phase A: lock, rounding, header pools
        try_send("R1 reset", 0, 0);
        fc_event(1, 0, 1, 1);
        fc_event(1, 1, 1, 1);
        try_send("R1 before lock", 0, 0);
        lock();
        try_send("R2 ten bytes", 0, 10);
        try_send("R3 header spent", 0, 0);
        try_send("R3 separate pool", 1, 5);
        try_send("R9 reserved code", 3, 0);

        // Phase B: data rounding, refusal leaves state, event windows
        do_reset();
        fc_event(1, 0, 127, 2);
        fc_event(0, 0, 127, 500);
        try_send("R7 update before lock ignored", 0, 33);
        lock();
        fc_event(1, 0, 0, 0);
        try_send("R7 init after lock ignored", 0, 33);
        try_send("R2 32 bytes", 0, 32);
        try_send("R2 zero bytes", 0, 0);
        try_send("R8 refused", 0, 1);
        try_send("R8 refused again", 0, 1);
        fc_event(0, 0, 127, 3);
        try_send("R8 after refusals", 0, 16);
        try_send("R2 17 bytes refused", 0, 17);

        // Phase C: unlimited pools
        do_reset();
        for (int c = 0; c < 3; c++) fc_event(1, c, 0, 0);
        lock();
        for (int i = 0; i < 300; i++) try_send("R5 unlimited", 2, 4000 + (i % 96));
        fc_event(0, 2, 1, 1);
        try_send("R6 update ignored", 2, 4095);
        try_send("R6 update ignored", 2, 4095);
        try_send("R9 reserved code", 3, 16);

        // Phase D: long mixed sweep with wrap
        do_reset();
        fc_event(1, 0, 10, 50);
        fc_event(1, 1, 5, 0);
        fc_event(1, 2, 0, 30);
        lock();
        for (int i = 0; i < 3000; i++) begin
            if (i % 5 == 0) begin
                int c = (i / 5) % 3;
                fc_event(0, c, con_h[c] + 2 + (i % 9), con_d[c] + 10 + (i % 60));
            end
            if (i % 97 == 0) fc_event(1, i % 3, 0, 0);
            try_send("R4 R10 sweep", i % 4, (i * 37) % 300);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule